// File: doc/BRIEF.md
# Indexed CD Data-Controller Host Register File

This block is the register file that a host processor sees in front of a CD data controller. The host cannot address the registers directly. It loads a 4-bit register index, then moves bytes through a single data port. The same index selects one of sixteen read registers on a read strobe and one of sixteen write registers on a write strobe. After most accesses the index steps to the next register by itself, so a host can stream through a group of registers without reloading the index.

The file holds the interface status and control bytes, the sector header bytes, the decode status bytes, the block pointer, the write address and the decoder control bytes. It also keeps the transfer byte counter and transfer address that it hands to the data-transfer engine, together with a transfer-running flag. A sticky mask records which decode-related registers the host has read since the last reset. Once every register in the retire set has been read and both decode enables are on, a read of the last decode status byte retires it by rewriting it to 0x80. A write to the last write index resets the controller in software.

Top module: `cdc_host_regs`

## Requirements
- R1: While `rd_stb` is high and `wr_stb` is low, `rdata` shows the selected read register in the same cycle: 0 command input, 1 interface status, 2/3 transfer count low/high, 4 to 7 header bytes 0 to 3, 8/9 block pointer low/high, 10/11 write address low/high, 12 to 15 decode status bytes 0 to 3. In any other cycle `rdata` is 0, and a read strobe that comes with a write strobe has no effect.
- R2: `idx_ld` loads `idx_val` into the index at the next edge and wins over auto-advance, while the access in that cycle still uses the old index. After a read the index advances by one, except after a read of index 15, which leaves it at 15.
- R3: Write indices select: 0 status out, 1 interface control, 2/3 transfer count low/high, 4/5 transfer address low/high, 6 transfer kick, 7 end acknowledge, 8/9 write address low/high, 10 decoder control 0, 11 decoder control 1, 12/13 block pointer low/high, 14 decoder control 2, 15 software reset. After a write the index advances by one, except after writes to 6, 7, 14 and 15, which leave it unchanged.
- R4: After `rst_n` the index is 0, interface status is 0xFF, decode status bytes 0 to 3 are 0x80, 0, 0, 0, header bytes 0 to 3 are 0, 0, 0, 0x01, and the write address is 4704 (0x1260). Every other register is 0, and `xfer_run` is low.
- R5: A read of index 1, 4 to 9, or 12 to 14 sets the mask bit at the same position as the index. Mask bits stay set until a reset.
- R6: A read of index 15 returns decode status byte 3 as it was and sets interface status bit 5. If decoder control 0 bit 7 and interface control bit 5 are both set and all mask bits of 0x73F2 are set, decode status byte 3 reads 0x80 from then on.
- R7: A write to index 15 restores every register to its R4 value and clears the read mask. The index stays at 15.
- R8: A write to interface control with bit 1 clear sets the transfer count to 0, sets interface status bit 3 and drops `xfer_run`.
- R9: A write to index 6 while interface control bit 1 is set clears interface status bit 3 and raises `xfer_run`. While bit 1 is clear the same write changes nothing.
- R10: A write to index 7 sets interface status bit 6.
- R11: `xfer_cnt` and `xfer_addr` are the 16-bit transfer count and address built from their byte writes. Block pointer and write address bytes read back at their read indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_ld | input | 1 | Load the register index from `idx_val` |
| idx_val | input | 4 | New register index |
| rd_stb | input | 1 | Read strobe for the selected register |
| wr_stb | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| idx_cur | output | 4 | Current register index |
| xfer_cnt | output | 16 | Transfer byte counter for the transfer engine |
| xfer_addr | output | 16 | Transfer address for the transfer engine |
| xfer_run | output | 1 | Transfer started and not stopped |

## Verification
The bench goes after the index hold points: reads at 15 and writes at 6, 7, 14 and 15. A design that advanced past them would wrap to 0 or skip a register, and every later index check would go wrong. The decode retire is tested three ways: with the enables off, with a mask that lacks one bit (index 13) after a software reset, and with the full mask left over from earlier reads. A mask that was not sticky, was not cleared by the software reset, or was checked in the wrong cycle would give a wrong byte 3. The bench also tries a read and a write strobe in the same cycle, an index load together with a read, and a kick while transfers are disabled. A design that got these wrong would return data during a write, lose the load, or start a transfer. Seeded random traffic then checks every result against a bench model.

// File: rtl/cdcr_pkg.sv
package cdcr_pkg;

   localparam int unsigned REG_CNT = 16;

   typedef enum logic [3:0] {
      RD_CMD_IN    = 4'd0,
      RD_HOST_STAT = 4'd1,
      RD_CNT_LO    = 4'd2,
      RD_CNT_HI    = 4'd3,
      RD_HDR0      = 4'd4,
      RD_HDR1      = 4'd5,
      RD_HDR2      = 4'd6,
      RD_HDR3      = 4'd7,
      RD_PTR_LO    = 4'd8,
      RD_PTR_HI    = 4'd9,
      RD_WA_LO     = 4'd10,
      RD_WA_HI     = 4'd11,
      RD_DSTAT0    = 4'd12,
      RD_DSTAT1    = 4'd13,
      RD_DSTAT2    = 4'd14,
      RD_DSTAT3    = 4'd15
   } rd_sel_e;

   typedef enum logic [3:0] {
      WR_STS_OUT   = 4'd0,
      WR_HOST_CTL  = 4'd1,
      WR_CNT_LO    = 4'd2,
      WR_CNT_HI    = 4'd3,
      WR_ADR_LO    = 4'd4,
      WR_ADR_HI    = 4'd5,
      WR_KICK      = 4'd6,
      WR_ACK       = 4'd7,
      WR_WA_LO     = 4'd8,
      WR_WA_HI     = 4'd9,
      WR_DCTL0     = 4'd10,
      WR_DCTL1     = 4'd11,
      WR_PTR_LO    = 4'd12,
      WR_PTR_HI    = 4'd13,
      WR_DCTL2     = 4'd14,
      WR_SOFT_RST  = 4'd15
   } wr_sel_e;

   // bit positions inside the interface status / control bytes
   localparam int HS_IDLE_B  = 3;
   localparam int HS_DECI_B  = 5;
   localparam int HS_ENDI_B  = 6;
   localparam int HC_XFER_B  = 1;
   localparam int HC_DECIE_B = 5;
   localparam int DC0_DEC_B  = 7;

endpackage

// File: rtl/cdcr_idx_seq.sv
module cdcr_idx_seq #(
   parameter int unsigned IDX_W = 4,
   parameter logic [(1<<IDX_W)-1:0] RD_HOLD = 16'h8000,
   parameter logic [(1<<IDX_W)-1:0] WR_HOLD = 16'hC0C0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [IDX_W-1:0] ld_val,
   input  logic             rd_go,
   input  logic             wr_go,
   output logic [IDX_W-1:0] idx_q
);

   if (IDX_W < 1) begin : g_bad_idx_w
      $error("cdcr_idx_seq: IDX_W must be at least 1");
   end

   logic step;

   always_comb begin
      step = 1'b0;
      if (wr_go)      step = !WR_HOLD[idx_q];
      else if (rd_go) step = !RD_HOLD[idx_q];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx_q <= '0;
      else if (ld)   idx_q <= ld_val;
      else if (step) idx_q <= idx_q + 1'b1;
   end

   // R2
   idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> idx_q == $past(ld_val));

   // R2
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && !wr_go && !ld && !RD_HOLD[idx_q]) |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

   // R3
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && !ld && WR_HOLD[idx_q]) |=> $stable(idx_q));

endmodule

// File: rtl/cdcr_read_track.sv
module cdcr_read_track #(
   parameter int unsigned NREG = 16,
   parameter logic [NREG-1:0] TRACK  = 16'h73F2,
   parameter logic [NREG-1:0] RETIRE = 16'h73F2,
   localparam int unsigned IW = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          rd_go,
   input  logic [IW-1:0] idx,
   output logic          all_seen
);

   if ((RETIRE & ~TRACK) != '0) begin : g_bad_retire
      $error("cdcr_read_track: RETIRE must be a subset of TRACK");
   end

   logic [NREG-1:0] seen;

   for (genvar i = 0; i < NREG; i++) begin : g_bit
      if (TRACK[i]) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        seen[i] <= 1'b0;
            else if (clr)                      seen[i] <= 1'b0;
            else if (rd_go && idx == IW'(i))   seen[i] <= 1'b1;
         end
      end else begin : g_none
         assign seen[i] = 1'b0;
      end
   end

   assign all_seen = &(seen | ~RETIRE);

   // R5
   mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && !clr && TRACK[idx]) |=> seen[$past(idx)]);

   // R5
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (seen & $past(seen)) == $past(seen));

   // R7
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> seen == '0);

endmodule

// File: rtl/cdcr_regbank.sv
module cdcr_regbank
   import cdcr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WA_RST = 4704,
   parameter logic [4*DATA_W-1:0] HDR_RST   = 32'h0100_0000,
   parameter logic [4*DATA_W-1:0] DSTAT_RST = 32'h0000_0080,
   localparam int unsigned CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  logic              wr_go,
   input  logic [3:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              all_seen,
   output logic [DATA_W-1:0] rdata,
   output logic              soft_rst,
   output logic [CNT_W-1:0]  xfer_cnt,
   output logic [CNT_W-1:0]  xfer_addr,
   output logic              xfer_run
);

   if (DATA_W < 8) begin : g_bad_data_w
      $error("cdcr_regbank: DATA_W must be at least 8");
   end

   localparam logic [DATA_W-1:0] DSTAT_DONE = DATA_W'(8'h80);

   typedef struct packed {
      logic [DATA_W-1:0]        cmd_in;
      logic [DATA_W-1:0]        host_stat;
      logic [DATA_W-1:0]        host_ctl;
      logic [DATA_W-1:0]        sts_out;
      logic [DATA_W-1:0]        dctl0;
      logic [DATA_W-1:0]        dctl1;
      logic [DATA_W-1:0]        dctl2;
      logic [3:0][DATA_W-1:0]   hdr;
      logic [3:0][DATA_W-1:0]   dstat;
      logic [CNT_W-1:0]         cnt;
      logic [CNT_W-1:0]         adr;
      logic [CNT_W-1:0]         ptr;
      logic [CNT_W-1:0]         wa;
      logic                     run;
   } regs_t;

   localparam regs_t RST = '{
      cmd_in:    '0,
      host_stat: '1,
      host_ctl:  '0,
      sts_out:   '0,
      dctl0:     '0,
      dctl1:     '0,
      dctl2:     '0,
      hdr:       HDR_RST,
      dstat:     DSTAT_RST,
      cnt:       '0,
      adr:       '0,
      ptr:       '0,
      wa:        CNT_W'(WA_RST),
      run:       1'b0
   };

   regs_t r, nxt;

   assign soft_rst = wr_go && (idx == WR_SOFT_RST);

   always_comb begin
      nxt = r;
      if (soft_rst) begin
         nxt = RST;
      end else if (wr_go) begin
         case (wr_sel_e'(idx))
            WR_STS_OUT:  nxt.sts_out = wdata;
            WR_HOST_CTL: begin
               nxt.host_ctl = wdata;
               if (!wdata[HC_XFER_B]) begin
                  nxt.cnt                  = '0;
                  nxt.run                  = 1'b0;
                  nxt.host_stat[HS_IDLE_B] = 1'b1;
               end
            end
            WR_CNT_LO:   nxt.cnt[DATA_W-1:0]      = wdata;
            WR_CNT_HI:   nxt.cnt[CNT_W-1:DATA_W]  = wdata;
            WR_ADR_LO:   nxt.adr[DATA_W-1:0]      = wdata;
            WR_ADR_HI:   nxt.adr[CNT_W-1:DATA_W]  = wdata;
            WR_KICK: begin
               if (r.host_ctl[HC_XFER_B]) begin
                  nxt.host_stat[HS_IDLE_B] = 1'b0;
                  nxt.run                  = 1'b1;
               end
            end
            WR_ACK:      nxt.host_stat[HS_ENDI_B] = 1'b1;
            WR_WA_LO:    nxt.wa[DATA_W-1:0]       = wdata;
            WR_WA_HI:    nxt.wa[CNT_W-1:DATA_W]   = wdata;
            WR_DCTL0:    nxt.dctl0 = wdata;
            WR_DCTL1:    nxt.dctl1 = wdata;
            WR_PTR_LO:   nxt.ptr[DATA_W-1:0]      = wdata;
            WR_PTR_HI:   nxt.ptr[CNT_W-1:DATA_W]  = wdata;
            WR_DCTL2:    nxt.dctl2 = wdata;
            default:     ;
         endcase
      end else if (rd_go && (idx == RD_DSTAT3)) begin
         nxt.host_stat[HS_DECI_B] = 1'b1;
         if (r.dctl0[DC0_DEC_B] && r.host_ctl[HC_DECIE_B] && all_seen)
            nxt.dstat[3] = DSTAT_DONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST;
      else        r <= nxt;
   end

   always_comb begin
      rdata = '0;
      if (rd_go) begin
         case (rd_sel_e'(idx))
            RD_CMD_IN:    rdata = r.cmd_in;
            RD_HOST_STAT: rdata = r.host_stat;
            RD_CNT_LO:    rdata = r.cnt[DATA_W-1:0];
            RD_CNT_HI:    rdata = r.cnt[CNT_W-1:DATA_W];
            RD_HDR0:      rdata = r.hdr[0];
            RD_HDR1:      rdata = r.hdr[1];
            RD_HDR2:      rdata = r.hdr[2];
            RD_HDR3:      rdata = r.hdr[3];
            RD_PTR_LO:    rdata = r.ptr[DATA_W-1:0];
            RD_PTR_HI:    rdata = r.ptr[CNT_W-1:DATA_W];
            RD_WA_LO:     rdata = r.wa[DATA_W-1:0];
            RD_WA_HI:     rdata = r.wa[CNT_W-1:DATA_W];
            RD_DSTAT0:    rdata = r.dstat[0];
            RD_DSTAT1:    rdata = r.dstat[1];
            RD_DSTAT2:    rdata = r.dstat[2];
            RD_DSTAT3:    rdata = r.dstat[3];
            default:      rdata = '0;
         endcase
      end
   end

   assign xfer_cnt  = r.cnt;
   assign xfer_addr = r.adr;
   assign xfer_run  = r.run;

   logic unused_bits;
   assign unused_bits = ^{r.sts_out, r.dctl1, r.dctl2, r.host_ctl, r.dctl0};

   // R8
   halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && idx == WR_HOST_CTL && !wdata[HC_XFER_B]) |=> (xfer_cnt == '0) && !xfer_run);

   // R9
   kick_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && idx == WR_KICK && !r.host_ctl[HC_XFER_B]) |=> $stable(xfer_run) && $stable(r.host_stat));

   // R6
   retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && idx == RD_DSTAT3 && r.dctl0[DC0_DEC_B] && r.host_ctl[HC_DECIE_B] && all_seen)
      |=> r.dstat[3] == DSTAT_DONE);

   // R7
   soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (xfer_cnt == '0) && (xfer_addr == '0) && !xfer_run);

endmodule

// File: rtl/cdc_host_regs.sv
module cdc_host_regs
   import cdcr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned WA_RST = 4704,
   parameter logic [(1<<IDX_W)-1:0] TRACK_MASK  = 16'h73F2,
   parameter logic [(1<<IDX_W)-1:0] RETIRE_MASK = 16'h73F2,
   localparam int unsigned NREG  = 1 << IDX_W,
   localparam int unsigned CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_ld,
   input  logic [IDX_W-1:0]  idx_val,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [IDX_W-1:0]  idx_cur,
   output logic [CNT_W-1:0]  xfer_cnt,
   output logic [CNT_W-1:0]  xfer_addr,
   output logic              xfer_run
);

   if (NREG != REG_CNT) begin : g_bad_map
      $error("cdc_host_regs: register map needs exactly 16 indices");
   end

   logic rd_go, wr_go, soft_rst, all_seen;

   assign wr_go = wr_stb;
   assign rd_go = rd_stb && !wr_stb;

   cdcr_idx_seq #(
      .IDX_W   (IDX_W),
      .RD_HOLD (16'h8000),
      .WR_HOLD (16'hC0C0)
   ) u_idx (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (idx_ld),
      .ld_val (idx_val),
      .rd_go  (rd_go),
      .wr_go  (wr_go),
      .idx_q  (idx_cur)
   );

   cdcr_read_track #(
      .NREG   (NREG),
      .TRACK  (TRACK_MASK),
      .RETIRE (RETIRE_MASK)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_rst),
      .rd_go    (rd_go),
      .idx      (idx_cur),
      .all_seen (all_seen)
   );

   cdcr_regbank #(
      .DATA_W (DATA_W),
      .WA_RST (WA_RST)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_go     (rd_go),
      .wr_go     (wr_go),
      .idx       (idx_cur),
      .wdata     (wdata),
      .all_seen  (all_seen),
      .rdata     (rdata),
      .soft_rst  (soft_rst),
      .xfer_cnt  (xfer_cnt),
      .xfer_addr (xfer_addr),
      .xfer_run  (xfer_run)
   );

endmodule

// File: tb/cdc_host_regs_tb.sv
module cdc_host_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        idx_ld, rd_stb, wr_stb;
   logic [3:0]  idx_val;
   logic [7:0]  wdata, rdata;
   logic [3:0]  idx_cur;
   logic [15:0] xfer_cnt, xfer_addr;
   logic        xfer_run;

   always #10 clk = ~clk;

   cdc_host_regs u_dut (
      .clk(clk), .rst_n(rst_n), .idx_ld(idx_ld), .idx_val(idx_val),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata),
      .idx_cur(idx_cur), .xfer_cnt(xfer_cnt), .xfer_addr(xfer_addr),
      .xfer_run(xfer_run)
   );

   int n_vec = 0;
   int n_bad = 0;

   // bench model of the register file, built from the requirements
   logic [3:0]  m_idx;
   logic [7:0]  m_hstat, m_hctl, m_dctl0;
   logic [15:0] m_cnt, m_adr, m_ptr, m_wa, m_mask;
   logic [7:0]  m_dstat [4];
   logic        m_run;

   task automatic m_reset();
      m_hstat = 8'hFF; m_hctl = 8'h00; m_dctl0 = 8'h00;
      m_cnt = 16'h0; m_adr = 16'h0; m_ptr = 16'h0; m_wa = 16'd4704;
      m_dstat[0] = 8'h80; m_dstat[1] = 8'h00; m_dstat[2] = 8'h00; m_dstat[3] = 8'h00;
      m_mask = 16'h0; m_run = 1'b0;
   endtask

   function automatic logic [7:0] m_rd(input logic [3:0] i);
      case (i)
         4'd0:  return 8'h00;
         4'd1:  return m_hstat;
         4'd2:  return m_cnt[7:0];
         4'd3:  return m_cnt[15:8];
         4'd7:  return 8'h01;
         4'd8:  return m_ptr[7:0];
         4'd9:  return m_ptr[15:8];
         4'd10: return m_wa[7:0];
         4'd11: return m_wa[15:8];
         4'd12: return m_dstat[0];
         4'd13: return m_dstat[1];
         4'd14: return m_dstat[2];
         4'd15: return m_dstat[3];
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // one host cycle; entered just after a falling edge
   task automatic op(input logic rd, input logic wr, input logic ld,
                     input logic [3:0] ldv, input logic [7:0] d, input string tag);
      logic [3:0] cur;
      logic       adv;
      rd_stb = rd; wr_stb = wr; idx_ld = ld; idx_val = ldv; wdata = d;
      #2;
      check({tag, " rdata"}, 32'(rdata), (rd && !wr) ? 32'(m_rd(m_idx)) : 32'h0);
      @(posedge clk);
      #1;
      cur = m_idx;
      adv = 1'b0;
      if (wr) begin
         adv = !(cur inside {4'd6, 4'd7, 4'd14, 4'd15});
         case (cur)
            4'd1: begin
               m_hctl = d;
               if (!d[1]) begin m_cnt = 16'h0; m_run = 1'b0; m_hstat[3] = 1'b1; end
            end
            4'd2:  m_cnt[7:0]  = d;
            4'd3:  m_cnt[15:8] = d;
            4'd4:  m_adr[7:0]  = d;
            4'd5:  m_adr[15:8] = d;
            4'd6:  if (m_hctl[1]) begin m_hstat[3] = 1'b0; m_run = 1'b1; end
            4'd7:  m_hstat[6] = 1'b1;
            4'd8:  m_wa[7:0]   = d;
            4'd9:  m_wa[15:8]  = d;
            4'd10: m_dctl0     = d;
            4'd12: m_ptr[7:0]  = d;
            4'd13: m_ptr[15:8] = d;
            4'd15: m_reset();
            default: ;
         endcase
      end else if (rd) begin
         adv = (cur != 4'd15);
         if (16'h73F2 & (16'h1 << cur)) m_mask[cur] = 1'b1;
         if (cur == 4'd15) begin
            m_hstat[5] = 1'b1;
            if (m_dctl0[7] && m_hctl[5] && ((m_mask & 16'h73F2) == 16'h73F2))
               m_dstat[3] = 8'h80;
         end
      end
      m_idx = ld ? ldv : (adv ? cur + 4'd1 : cur);
      rd_stb = 1'b0; wr_stb = 1'b0; idx_ld = 1'b0;
      check(wr ? "R3 index" : "R2 index", 32'(idx_cur), 32'(m_idx));
      check("R11 xfer_cnt", 32'(xfer_cnt), 32'(m_cnt));
      check("R11 xfer_addr", 32'(xfer_addr), 32'(m_adr));
      check("R9 xfer_run", 32'(xfer_run), 32'(m_run));
      @(negedge clk);
   endtask

   task automatic rd_at(input logic [3:0] i, input string tag);
      op(1'b0, 1'b0, 1'b1, i, 8'h00, "R2 load");
      op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, tag);
   endtask

   task automatic wr_at(input logic [3:0] i, input logic [7:0] d, input string tag);
      op(1'b0, 1'b0, 1'b1, i, 8'h00, "R2 load");
      op(1'b0, 1'b1, 1'b0, 4'd0, d, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'h5EED_C0DE;
      void'($urandom(seed));
      rst_n = 1'b0; idx_ld = 0; rd_stb = 0; wr_stb = 0; idx_val = '0; wdata = '0;
      m_reset(); m_idx = 4'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 reset state at the ports
      check("R4 idx", 32'(idx_cur), 32'h0);
      check("R4 cnt", 32'(xfer_cnt), 32'h0);
      check("R4 addr", 32'(xfer_addr), 32'h0);
      check("R4 run", 32'(xfer_run), 32'h0);
      // R4 walk every read register; R2 auto-advance; R5 fills the mask
      for (int i = 0; i < 16; i++) op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R4 walk");
      op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R2 hold at 15");
      // R6 enables on, mask already full from the walk (R5 sticky)
      wr_at(4'd10, 8'h80, "R3 dctl0");
      wr_at(4'd1, 8'h22, "R8 host_ctl");
      rd_at(4'd15, "R6 old value");
      op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R6 retired");
      rd_at(4'd1, "R6 stat bit5");
      // R7 software reset clears mask and registers, index stays 15
      wr_at(4'd15, 8'h00, "R7 soft reset");
      op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R7 dstat3");
      rd_at(4'd1, "R7 host_stat");
      rd_at(4'd10, "R7 wa low");
      wr_at(4'd10, 8'h80, "R7 dctl0");
      wr_at(4'd1, 8'h20, "R7 host_ctl");
      rd_at(4'd15, "R7 no retire");
      op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R7 no retire");
      // R5 partial mask: everything but 13
      rd_at(4'd1, "R5 partial");
      op(1'b0, 1'b0, 1'b1, 4'd4, 8'h00, "R2 load");
      for (int i = 0; i < 6; i++) op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R5 partial");
      rd_at(4'd12, "R5 partial");
      rd_at(4'd14, "R5 partial");
      rd_at(4'd15, "R5 partial no retire");
      op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R5 partial no retire");
      rd_at(4'd13, "R5 last bit");
      rd_at(4'd15, "R6 retire");
      op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R6 retired");
      // transfer set-up, kick, ack, halt
      wr_at(4'd1, 8'h02, "R8 enable");
      op(1'b0, 1'b1, 1'b0, 4'd0, 8'h34, "R11 cnt lo");
      op(1'b0, 1'b1, 1'b0, 4'd0, 8'h12, "R11 cnt hi");
      op(1'b0, 1'b1, 1'b0, 4'd0, 8'h78, "R11 adr lo");
      op(1'b0, 1'b1, 1'b0, 4'd0, 8'h56, "R11 adr hi");
      op(1'b0, 1'b1, 1'b0, 4'd0, 8'h00, "R9 kick");
      op(1'b0, 1'b1, 1'b0, 4'd0, 8'h00, "R3 kick hold");
      wr_at(4'd7, 8'h00, "R10 ack");
      rd_at(4'd1, "R9 stat bit3 low");
      rd_at(4'd2, "R11 cnt readback");
      wr_at(4'd1, 8'h00, "R8 halt");
      rd_at(4'd1, "R8 stat bit3 high");
      wr_at(4'd6, 8'h00, "R9 kick disabled");
      wr_at(4'd14, 8'h5A, "R3 dctl2 hold");
      // R11 write address and block pointer readback
      wr_at(4'd8, 8'hAA, "R11 wa lo");
      op(1'b0, 1'b1, 1'b0, 4'd0, 8'hBB, "R11 wa hi");
      op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R11 wa read lo");
      op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R11 wa read hi");
      wr_at(4'd12, 8'h11, "R11 ptr lo");
      op(1'b0, 1'b1, 1'b0, 4'd0, 8'h22, "R11 ptr hi");
      rd_at(4'd8, "R11 ptr read lo");
      op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R11 ptr read hi");
      // R1 read ignored during write; R2 load wins over a read
      op(1'b0, 1'b0, 1'b1, 4'd3, 8'h00, "R2 load");
      op(1'b1, 1'b1, 1'b0, 4'd0, 8'h9C, "R1 rd with wr");
      op(1'b1, 1'b0, 1'b1, 4'd11, 8'h00, "R2 load with read");
      op(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R1 read");
      // random traffic
      for (int n = 0; n < 1500; n++) begin
         int unsigned k;
         logic ld;
         k  = $urandom % 20;
         ld = ($urandom % 8) == 0;
         if (k < 8)       op(1'b1, 1'b0, ld, 4'($urandom), 8'h00, "R1 random read");
         else if (k < 16) op(1'b0, 1'b1, ld, 4'($urandom), 8'($urandom), "R3 random write");
         else if (k < 17) op(1'b1, 1'b1, ld, 4'($urandom), 8'($urandom), "R1 random both");
         else             op(1'b0, 1'b0, 1'b1, 4'($urandom), 8'h00, "R2 random load");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule